// File: doc/BRIEF.md
# Ripple-Chained Eight-Operation ALU

This block is a combinational arithmetic and logic unit built from identical one-bit cells connected in a ripple chain. A 3-bit operation code selects one of eight results. The codes are constant zero, constant all-ones, bitwise XOR, OR and AND, unsigned addition, and subtraction in both operand orders. Each cell contains a single full adder. Gating in front of the adder, driven by the operation code, selects which operand reaches it and whether that operand is inverted. All three arithmetic codes therefore share one adder per bit.

A small seed stage places the initial carry into the least significant cell. The seed is 1 for either subtraction code, which completes the two's complement of the inverted subtrahend, and 0 for addition. The carry leaving the most significant cell is the carry-out port. For subtraction it reads 1 when no borrow occurred. For the logic and constant codes it is held at 0.

The block holds no state, and the result follows the inputs within the same cycle. The operand width is set by the parameter `WIDTH`.

Top module: `alu_ripple_n`

## Requirements
- R1: Code 000 drives every result bit to 0 and carry_out to 0.
- R2: Code 001 gives result = (B - A) mod 2^WIDTH and carry_out = 1 exactly when B >= A (unsigned).
- R3: Code 010 gives result = (A - B) mod 2^WIDTH and carry_out = 1 exactly when A >= B (unsigned).
- R4: Code 011 gives result = (A + B) mod 2^WIDTH with a carry-in of 0 into bit 0, and carry_out equal to bit WIDTH of the full sum.
- R5: Code 100 gives result = A XOR B, bit by bit.
- R6: Code 101 gives result = A OR B, bit by bit.
- R7: Code 110 gives result = A AND B, bit by bit.
- R8: Code 111 drives every result bit to 1.
- R9: For codes 000, 100, 101, 110 and 111, carry_out is 0 for every operand pair.
- R10: The outputs depend only on the present inputs and settle within the same cycle, with no clock or stored state involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code; the encoding is given in R1 to R8 |
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| result | output | WIDTH | Result of the selected operation |
| carry_out | output | 1 | Carry from the top cell for the arithmetic codes, otherwise 0 |

## Verification
The block holds no state, so the only hidden values are the carry seed, the gating in front of each cell's adder, and the carries between cells. Every one of these appears at the ports in the same cycle the inputs change.

The kinds of fault show up differently:
- A wrong seed puts an off-by-one error into every subtraction or addition, starting at bit 0.
- Gating that swaps or fails to invert an operand makes the two subtraction codes give the same result, or makes a subtraction give an addition.
- A broken link between cells is only visible when a carry has to cross that link.

Exhaustive operand sweeps for each code therefore expose all three kinds of fault.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    typedef enum logic [2:0] {
        OP_ZERO  = 3'b000,
        OP_BSUBA = 3'b001,
        OP_ASUBB = 3'b010,
        OP_ADD   = 3'b011,
        OP_XOR   = 3'b100,
        OP_OR    = 3'b101,
        OP_AND   = 3'b110,
        OP_ONES  = 3'b111
    } op_e;

    function automatic logic is_subtract(input op_e op);
        return (op == OP_BSUBA) || (op == OP_ASUBB);
    endfunction

endpackage

// File: rtl/alu_full_add.sv
module alu_full_add (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);

    logic half_sum;

    always_comb begin
        half_sum = x_in ^ y_in;
        s_out    = half_sum ^ c_in;
        c_out    = (x_in & y_in) | (half_sum & c_in);
    end

endmodule

// File: rtl/alu_carry_seed.sv
module alu_carry_seed
    import alu_slice_pkg::*;
(
    input  op_e  op,
    output logic seed
);

    // Subtraction completes the two's complement of the inverted subtrahend.
    always_comb begin
        seed = is_subtract(op);
    end

endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
    import alu_slice_pkg::*;
(
    input  op_e  op,
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic f,
    output logic co
);

    logic fa_x;
    logic fa_y;
    logic fa_sum;
    logic fa_carry;

    // Operand gating in front of the shared adder.
    always_comb begin
        unique case (op)
            OP_BSUBA: begin fa_x = b;    fa_y = ~a;   end
            OP_ASUBB: begin fa_x = a;    fa_y = ~b;   end
            OP_ADD:   begin fa_x = a;    fa_y = b;    end
            default:  begin fa_x = 1'b0; fa_y = 1'b0; end
        endcase
    end

    alu_full_add adder_i (
        .x_in  (fa_x),
        .y_in  (fa_y),
        .c_in  (ci),
        .s_out (fa_sum),
        .c_out (fa_carry)
    );

    // Result selection; the carry is only passed on for the arithmetic codes.
    always_comb begin
        unique case (op)
            OP_ZERO:  begin f = 1'b0;    co = 1'b0;     end
            OP_BSUBA,
            OP_ASUBB,
            OP_ADD:   begin f = fa_sum;  co = fa_carry; end
            OP_XOR:   begin f = a ^ b;   co = 1'b0;     end
            OP_OR:    begin f = a | b;   co = 1'b0;     end
            OP_AND:   begin f = a & b;   co = 1'b0;     end
            OP_ONES:  begin f = 1'b1;    co = 1'b0;     end
            default:  begin f = 1'b0;    co = 1'b0;     end
        endcase
    end

endmodule

// File: rtl/alu_ripple_n.sv
module alu_ripple_n
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int CHAIN_LEN = WIDTH + 1;

    op_e                  op;
    logic [CHAIN_LEN-1:0] chain;

    always_comb begin
        op = op_e'(op_sel);
    end

    alu_carry_seed seed_i (
        .op   (op),
        .seed (chain[0])
    );

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        alu_bit_cell cell_i (
            .op (op),
            .a  (opnd_a[gi]),
            .b  (opnd_b[gi]),
            .ci (chain[gi]),
            .f  (result[gi]),
            .co (chain[gi+1])
        );
    end

    always_comb begin
        carry_out = chain[CHAIN_LEN-1];
    end

endmodule

// File: rtl/alu_ripple_n_chk.sv
module alu_ripple_n_chk #(
    parameter int WIDTH = 4
) (
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);

    logic [WIDTH:0] wide_a;
    logic [WIDTH:0] wide_b;

    always_comb begin
        wide_a = {1'b0, opnd_a};
        wide_b = {1'b0, opnd_b};
        if (op_sel == 3'b000) begin
            // R1
            zero_result_chk: assert (result == '0);
        end
        if (op_sel == 3'b111) begin
            // R8
            ones_result_chk: assert (result == '1);
        end
        if (op_sel == 3'b000 || op_sel[2]) begin
            // R9
            no_logic_carry_chk: assert (carry_out == 1'b0);
        end
        if (op_sel == 3'b011) begin
            // R4
            add_sum_chk: assert ({carry_out, result} == wide_a + wide_b);
        end
        if (op_sel == 3'b010) begin
            // R3
            a_minus_b_chk: assert (result == opnd_a - opnd_b && carry_out == (opnd_a >= opnd_b));
        end
        if (op_sel == 3'b001) begin
            // R2
            b_minus_a_chk: assert (result == opnd_b - opnd_a && carry_out == (opnd_b >= opnd_a));
        end
    end

endmodule

bind alu_ripple_n alu_ripple_n_chk #(.WIDTH(WIDTH)) chk_i (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/alu_ripple_n_tb_top.sv
`timescale 1ns/1ps
module alu_ripple_n_tb_top;

    localparam int W = 4;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_sel = 3'b000;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu_ripple_n #(.WIDTH(W)) dut_i (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic logic [W:0] expect_val(input logic [2:0] op,
                                              input logic [W-1:0] a,
                                              input logic [W-1:0] b);
        logic [W:0] wa = {1'b0, a};
        logic [W:0] wb = {1'b0, b};
        case (op)
            3'd0: return '0;
            3'd1: return wb + {1'b0, ~a & MASK} + 1;
            3'd2: return wa + {1'b0, ~b & MASK} + 1;
            3'd3: return wa + wb;
            3'd4: return {1'b0, a ^ b};
            3'd5: return {1'b0, a | b};
            3'd6: return {1'b0, a & b};
            default: return {1'b0, MASK};
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                     tag, op_sel, opnd_a, opnd_b, got, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] e;
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        e = expect_val(op, a, b);
        check(op_tag(op), {carry_out, result}, e);
        if (op == 3'd0 || op[2]) check("R9", {W'(0), carry_out}, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state: code 000 with zero operands gives all zeros (R1)
        check("R1", {carry_out, result}, '0);
        rst_n = 1'b1;

        // Directed corners
        apply(3'd2, 4'h0, 4'h1);
        apply(3'd1, 4'h1, 4'h0);
        apply(3'd3, 4'hF, 4'h1);
        apply(3'd2, 4'h7, 4'h7);
        apply(3'd1, 4'hF, 4'hF);

        // Exhaustive sweep for every code
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    apply(op[2:0], a[W-1:0], b[W-1:0]);

        // Random mix with a fixed seed
        void'($urandom(32'h5eed));
        for (int k = 0; k < 400; k++)
            apply(3'($urandom()), W'($urandom()), W'($urandom()));

        // R10: outputs follow an input change without any clock edge
        @(negedge clk);
        op_sel = 3'd3; opnd_a = 4'h9; opnd_b = 4'h8;
        #1;
        check("R10", {carry_out, result}, 5'h11);
        op_sel = 3'd2;
        #1;
        check("R10", {carry_out, result}, 5'h11);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule